// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM with 16-bit words split into two byte lanes. The host gives a one-cycle request pulse that carries a write flag, a 21-bit word address, write data and a two-bit lane mask. The controller turns that pulse into a timed sequence on the memory pins: two chip selects of opposite polarity, active-low write strobe, active-low output enable, two active-low lane enables, and a data bus split into an output word, a drive-enable and an input word. The pad itself sits outside the block.

Every analogue timing minimum is a nanosecond parameter. Elaboration turns each one into a whole number of clock cycles by rounding up. Each access passes through a select-setup phase, a strobe phase and a recovery phase. The recovery phase leaves the memory deselected and gives it time to release the bus. After reset the controller waits for a start-up interval before it accepts any access.

A single-cycle acknowledge closes each accepted request. For reads, the returned word comes with that acknowledge. A request with an empty lane mask is acknowledged at once, and the memory pins do not move.

Top module: `sram_async_ctrl`

## Requirements
- R1: Whenever no access is in progress, including during reset and start-up, the memory is deselected and quiet: `mem_ce_n`=1, `mem_ce`=0, `mem_we_n`=1, `mem_oe_n`=1, both lane enables 1 and `mem_dq_oe`=0.
- R2: For the start-up interval after reset (200 µs, which is 10000 clocks at 20 ns), no access is made and request pulses are dropped without an acknowledge.
- R3: Mask bit 0 selects the lower lane (data bits 7:0, `mem_lb_n`). Mask bit 1 selects the upper lane (bits 15:8, `mem_ub_n`). A write changes only the enabled lanes. A read returns the enabled lanes, and disabled lanes read as zero.
- R4: A request with mask 00 is acknowledged on the edge that accepts it. It causes no memory pin activity and leaves the memory unchanged.
- R5: Read data is captured only after the address and select have been stable for at least 70 ns and the output enable has been low for at least 35 ns.
- R6: The write strobe is low only while the memory is selected, at least one lane is enabled, the output enable is high and the bus is driven. It stays low for at least 45 ns. Address and select are valid at least 60 ns before it rises, and the data is driven and stable at least 30 ns before it rises.
- R7: The data bus is never driven while the output enable is low. The bus is not driven until at least 25 ns after the output enable rises.
- R8: Successive chip-select assertions are at least 70 ns apart.
- R9: Each accepted request gets exactly one single-cycle acknowledge. With default parameters it comes 6 rising edges after the accepting edge for a read and 5 for a write. Request pulses that arrive while an access is in progress are ignored.
- R10: `host_rdata` is valid with a read's acknowledge and holds until the next read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | One-cycle request pulse; fields valid with it |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 21 | Word address |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Lane mask, bit 0 lower lane, bit 1 upper lane |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read data, valid with acknowledge |
| mem_addr | output | 21 | Memory address |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_ub_n | output | 1 | Active-low upper lane enable |
| mem_lb_n | output | 1 | Active-low lower lane enable |
| mem_dq_out | output | 16 | Data toward memory |
| mem_dq_oe | output | 1 | Drive-enable for the data pad |
| mem_dq_in | input | 16 | Data from memory |

## Verification
The bench models the memory by time. It returns a garbage word whenever the address or output-enable age at the sampling edge is below the minimum, so a design that captures one cycle early returns corrupt data rather than merely failing a timing measure. Partial-lane writes followed by full and single-lane reads catch swapped or inverted lane enables, which would corrupt the wrong byte or leak stale bits into a masked lane. A read followed at once by a write measures the gap from the output-enable rise to the first bus drive, which a design without recovery would make too short. Request pulses sent during start-up and during an access would, if accepted, produce extra acknowledges or overwrite the word being written.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    localparam int ADDR_W = 21;
    localparam int LANES  = 2;
    localparam int DATA_W = 8 * LANES;

    typedef enum logic [2:0] {
        PH_BOOT,
        PH_IDLE,
        PH_SETUP,
        PH_ACTIVE,
        PH_RECOVER
    } phase_t;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  lanes;
    } access_t;

    // Round a nanosecond figure up to whole clock cycles.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_boot_timer.sv
module sram_boot_timer #(
    parameter int BOOT_CYC = 10000
) (
    input  logic clk,
    input  logic rst,
    output logic done_o
);
    localparam int CW = $clog2(BOOT_CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            done_o <= 1'b0;
        end else if (!done_o) begin
            if (cnt_q == CW'(BOOT_CYC - 1)) begin
                done_o <= 1'b1;
            end
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
    import sram_ctrl_pkg::*;
#(
    parameter int RD_SET = 1,
    parameter int RD_ACT = 3,
    parameter int RD_REC = 2,
    parameter int WR_SET = 1,
    parameter int WR_ACT = 3,
    parameter int WR_REC = 1,
    parameter int CNT_W  = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   boot_done_i,
    input  logic   start_i,
    input  logic   start_wr_i,
    input  logic   cur_wr_i,
    output phase_t phase_o,
    output logic   last_o
);
    phase_t           phase_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    assign last_o = (cnt_q == '0);

    always_comb begin
        phase_d = phase_o;
        cnt_d   = last_o ? cnt_q : cnt_q - 1'b1;
        unique case (phase_o)
            PH_BOOT: begin
                if (boot_done_i) phase_d = PH_IDLE;
            end
            PH_IDLE: begin
                if (start_i) begin
                    phase_d = PH_SETUP;
                    cnt_d   = start_wr_i ? CNT_W'(WR_SET - 1) : CNT_W'(RD_SET - 1);
                end
            end
            PH_SETUP: begin
                if (last_o) begin
                    phase_d = PH_ACTIVE;
                    cnt_d   = cur_wr_i ? CNT_W'(WR_ACT - 1) : CNT_W'(RD_ACT - 1);
                end
            end
            PH_ACTIVE: begin
                if (last_o) begin
                    phase_d = PH_RECOVER;
                    cnt_d   = cur_wr_i ? CNT_W'(WR_REC - 1) : CNT_W'(RD_REC - 1);
                end
            end
            PH_RECOVER: begin
                if (last_o) phase_d = PH_IDLE;
            end
            default: phase_d = PH_BOOT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_o <= PH_BOOT;
            cnt_q   <= '0;
        end else begin
            phase_o <= phase_d;
            cnt_q   <= cnt_d;
        end
    end
endmodule

// File: rtl/sram_pin_decode.sv
module sram_pin_decode
    import sram_ctrl_pkg::*;
(
    input  phase_t           phase_i,
    input  access_t          acc_i,
    output logic             sel_o,
    output logic             wstb_o,
    output logic             ostb_o,
    output logic             drive_o,
    output logic [LANES-1:0] lane_o
);
    logic in_cycle;

    always_comb begin
        in_cycle = (phase_i == PH_SETUP) || (phase_i == PH_ACTIVE);
        sel_o    = in_cycle;
        wstb_o   = (phase_i == PH_ACTIVE) && acc_i.wr;
        ostb_o   = (phase_i == PH_ACTIVE) && !acc_i.wr;
        drive_o  = in_cycle && acc_i.wr;
        lane_o   = in_cycle ? acc_i.lanes : '0;
    end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_NS    = 20,
    parameter int T_RC_NS   = 70,
    parameter int T_AA_NS   = 70,
    parameter int T_DOE_NS  = 35,
    parameter int T_HZOE_NS = 25,
    parameter int T_WC_NS   = 70,
    parameter int T_AW_NS   = 60,
    parameter int T_PWE_NS  = 45,
    parameter int T_SD_NS   = 30,
    parameter int T_BOOT_NS = 200000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [LANES-1:0]  host_be,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    // Phase lengths in clocks, each bounded below by one cycle.
    localparam int RD_SET   = 1;
    localparam int RD_ACT   = imax(imax(ns_to_cyc(T_DOE_NS, CLK_NS),
                                        ns_to_cyc(T_AA_NS, CLK_NS) - RD_SET), 1);
    localparam int RD_REC   = imax(imax(ns_to_cyc(T_HZOE_NS, CLK_NS),
                                        ns_to_cyc(T_RC_NS, CLK_NS) - RD_SET - RD_ACT), 1);
    localparam int WR_ACT   = imax(ns_to_cyc(T_PWE_NS, CLK_NS), 1);
    localparam int WR_SET   = imax(imax(ns_to_cyc(T_AW_NS, CLK_NS) - WR_ACT,
                                        ns_to_cyc(T_SD_NS, CLK_NS) - WR_ACT), 1);
    localparam int WR_REC   = imax(ns_to_cyc(T_WC_NS, CLK_NS) - WR_SET - WR_ACT, 1);
    localparam int BOOT_CYC = imax(ns_to_cyc(T_BOOT_NS, CLK_NS), 1);
    localparam int LONGEST  = imax(imax(imax(RD_ACT, RD_REC), imax(WR_SET, WR_ACT)),
                                   imax(WR_REC, RD_SET));
    localparam int CNT_W    = $clog2(LONGEST + 1);

    phase_t           phase;
    logic             last;
    logic             boot_done;
    access_t          acc_q;
    logic             accept, empty_req;
    logic             sel, wstb, ostb, drive;
    logic [LANES-1:0] lane_en;
    logic [DATA_W-1:0] rd_mask;

    assign accept    = (phase == PH_IDLE) && host_req && (|host_be);
    assign empty_req = (phase == PH_IDLE) && host_req && !(|host_be);

    sram_boot_timer #(.BOOT_CYC(BOOT_CYC)) u_boot (
        .clk    (clk),
        .rst    (rst),
        .done_o (boot_done)
    );

    sram_phase_seq #(
        .RD_SET(RD_SET), .RD_ACT(RD_ACT), .RD_REC(RD_REC),
        .WR_SET(WR_SET), .WR_ACT(WR_ACT), .WR_REC(WR_REC),
        .CNT_W (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .boot_done_i (boot_done),
        .start_i     (accept),
        .start_wr_i  (host_we),
        .cur_wr_i    (acc_q.wr),
        .phase_o     (phase),
        .last_o      (last)
    );

    sram_pin_decode u_pins (
        .phase_i (phase),
        .acc_i   (acc_q),
        .sel_o   (sel),
        .wstb_o  (wstb),
        .ostb_o  (ostb),
        .drive_o (drive),
        .lane_o  (lane_en)
    );

    // Lane-wide mask applied to captured read data.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rd_mask[8*g +: 8] = {8{acc_q.lanes[g]}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q      <= '0;
            host_ack   <= 1'b0;
            host_rdata <= '0;
        end else begin
            if (accept) begin
                acc_q <= '{wr: host_we, addr: host_addr, wdata: host_wdata, lanes: host_be};
            end
            if (phase == PH_ACTIVE && last && !acc_q.wr) begin
                host_rdata <= mem_dq_in & rd_mask;
            end
            host_ack <= empty_req || (phase == PH_RECOVER && last);
        end
    end

    assign mem_addr   = acc_q.addr;
    assign mem_ce_n   = !sel;
    assign mem_ce     = sel;
    assign mem_we_n   = !wstb;
    assign mem_oe_n   = !ostb;
    assign mem_lb_n   = !lane_en[0];
    assign mem_ub_n   = !lane_en[1];
    assign mem_dq_out = acc_q.wdata;
    assign mem_dq_oe  = drive;
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_NS    = 20,
    parameter int T_HZOE_NS = 25,
    parameter int T_PWE_NS  = 45,
    parameter int T_BOOT_NS = 200000
) (
    input logic clk,
    input logic rst,
    input logic host_ack,
    input logic mem_ce_n,
    input logic mem_ce,
    input logic mem_we_n,
    input logic mem_oe_n,
    input logic mem_ub_n,
    input logic mem_lb_n,
    input logic mem_dq_oe
);
    localparam int REL_CYC   = ns_to_cyc(T_HZOE_NS, CLK_NS);
    localparam int PULSE_CYC = ns_to_cyc(T_PWE_NS, CLK_NS);
    localparam int BOOT_CYC  = ns_to_cyc(T_BOOT_NS, CLK_NS);

    logic [31:0] boot_cnt;
    logic [7:0]  oe_hi_cnt;
    logic [7:0]  we_lo_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            boot_cnt  <= '0;
            oe_hi_cnt <= 8'(REL_CYC);
            we_lo_cnt <= '0;
        end else begin
            if (boot_cnt < 32'(BOOT_CYC)) boot_cnt <= boot_cnt + 1'b1;
            if (!mem_oe_n)                      oe_hi_cnt <= '0;
            else if (oe_hi_cnt < 8'(REL_CYC))   oe_hi_cnt <= oe_hi_cnt + 1'b1;
            if (!mem_we_n) we_lo_cnt <= we_lo_cnt + 1'b1;
            else           we_lo_cnt <= '0;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        mem_ce_n |-> (!mem_ce && mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n && !mem_dq_oe));

    assert_boot_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (boot_cnt < 32'(BOOT_CYC)) |-> (mem_ce_n && !host_ack));

    assert_wstrobe_qual_R6: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_ce_n && mem_ce && (!mem_ub_n || !mem_lb_n) && mem_oe_n && mem_dq_oe));

    assert_pulse_width_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_lo_cnt >= 8'(PULSE_CYC)));

    assert_no_contention_R7: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);

    assert_turnaround_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> (oe_hi_cnt >= 8'(REL_CYC)));

    assert_ack_deselected_R9: assert property (@(posedge clk) disable iff (rst)
        host_ack |-> (mem_ce_n && !mem_ce));
endmodule

bind sram_async_ctrl sram_async_ctrl_chk u_chk (.*);

// File: tb/sram_async_ctrl_tb.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb;
    localparam int BOOT_CLKS = 10000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [20:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [1:0]  host_be = '0;
    logic        host_ack;
    logic [15:0] host_rdata;
    logic [20:0] mem_addr;
    logic        mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = 16'hBAD0;

    always #10 clk = ~clk;

    sram_async_ctrl u_dut (.*);

    int nchk = 0, nfail = 0, cyc = 0;
    bit pend = 0, finished = 0;
    int exp_ack = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Behavioural memory with age-checked read data and write-end checks.
    logic [15:0] mem [int];
    time t_addr = 0, t_sel = 0, t_oe_fall = 0, t_oe_rise = 0, t_we_fall = 0, t_dat = 0;
    bit  have_sel = 0;
    logic [20:0] p_addr = '0;
    logic        p_sel = 0, p_oe_n = 1, p_we_n = 1, p_dq_oe = 0, p_ub_n = 1, p_lb_n = 1;
    logic [15:0] p_dq_out = '0;

    function automatic time tmax(input time a, input time b);
        return (a > b) ? a : b;
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            time t_edge;
            bit  sel, busy;
            logic [15:0] w;
            t_edge = $time - 10;
            sel    = !mem_ce_n && mem_ce;
            busy   = pend && (cyc < exp_ack);
            // R9 cycle-level acknowledge model
            chk(host_ack === (pend && cyc == exp_ack), "R9 ack cycle", host_ack, pend && cyc == exp_ack);
            if (pend && cyc == exp_ack) pend = 0;
            if (!busy)
                chk(mem_ce_n === 1 && mem_ce === 0 && mem_we_n === 1 && mem_oe_n === 1 &&
                    mem_ub_n === 1 && mem_lb_n === 1 && mem_dq_oe === 0,
                    "R1 idle pins", {mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe}, 7'b1011110);
            if (mem_we_n && !p_we_n) begin
                chk(t_edge - t_we_fall >= 45, "R6 strobe width", t_edge - t_we_fall, 45);
                chk(t_edge - tmax(t_addr, t_sel) >= 60, "R6 addr/select setup", t_edge - tmax(t_addr, t_sel), 60);
                chk(p_dq_oe && (t_edge - t_dat >= 30), "R6 data setup", t_edge - t_dat, 30);
                w = mem.exists(int'(p_addr)) ? mem[int'(p_addr)] : 16'h0000;
                if (!p_lb_n) w[7:0]  = p_dq_out[7:0];
                if (!p_ub_n) w[15:8] = p_dq_out[15:8];
                mem[int'(p_addr)] = w;
            end
            if (mem_addr !== p_addr) t_addr = t_edge;
            if (sel && !p_sel) begin
                if (have_sel) chk(t_edge - t_sel >= 70, "R8 select spacing", t_edge - t_sel, 70);
                t_sel = t_edge;
                have_sel = 1;
            end
            if (!mem_oe_n && p_oe_n) t_oe_fall = t_edge;
            if (mem_oe_n && !p_oe_n) t_oe_rise = t_edge;
            if (!mem_we_n && p_we_n) t_we_fall = t_edge;
            if (mem_dq_oe && !p_dq_oe)
                chk(mem_oe_n && (t_edge - t_oe_rise >= 25), "R7 bus turnaround", t_edge - t_oe_rise, 25);
            if (mem_dq_oe !== p_dq_oe || mem_dq_out !== p_dq_out) t_dat = t_edge;
            mem_dq_in = 16'hBAD0;
            if (sel && !mem_oe_n && mem_we_n && ($time + 10 - t_oe_fall >= 35) &&
                ($time + 10 - tmax(t_addr, t_sel) >= 70)) begin
                w = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'h0000;
                mem_dq_in = {mem_ub_n ? 8'hEE : w[15:8], mem_lb_n ? 8'hEE : w[7:0]};
            end
            p_addr = mem_addr; p_sel = sel; p_oe_n = mem_oe_n; p_we_n = mem_we_n;
            p_dq_oe = mem_dq_oe; p_ub_n = mem_ub_n; p_lb_n = mem_lb_n; p_dq_out = mem_dq_out;
        end
    end

    task automatic access(input bit wr, input logic [20:0] a, input logic [15:0] d,
                          input logic [1:0] be, input logic [15:0] exp_rd,
                          input bit inject, input string tag);
        @(negedge clk);
        host_req = 1; host_we = wr; host_addr = a; host_wdata = d; host_be = be;
        exp_ack = cyc + 1 + ((be == 2'b00) ? 0 : (wr ? 5 : 6));
        pend = 1;
        @(negedge clk);
        host_req = 0;
        if (inject) begin
            @(negedge clk);
            host_req = 1; host_we = 1; host_wdata = ~d; host_be = 2'b11;
            @(negedge clk);
            host_req = 0;
        end
        for (int k = 0; k < 40 && !host_ack; k++) @(negedge clk);
        chk(host_ack === 1'b1, {tag, " ack seen"}, host_ack, 1);
        if (!wr && be != 2'b00) chk(host_rdata === exp_rd, tag, host_rdata, exp_rd);
    endtask

    initial begin
        int acks;
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(mem_ce_n === 1 && mem_ce === 0 && host_ack === 0 && mem_dq_oe === 0,
            "R1 reset state", {mem_ce_n, mem_ce, host_ack, mem_dq_oe}, 4'b1000);
        // R2: a request during start-up is dropped
        repeat (20) @(negedge clk);
        host_req = 1; host_we = 1; host_addr = 21'h5; host_wdata = 16'hDEAD; host_be = 2'b11;
        @(negedge clk);
        host_req = 0;
        acks = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (host_ack) acks++;
        end
        chk(acks == 0, "R2 request ignored in start-up", acks, 0);
        while (cyc < BOOT_CLKS + 20) @(negedge clk);

        // R3 R5 R6: full word, then lane-wise updates
        access(1, 21'h12345, 16'hA5C3, 2'b11, 16'h0, 0, "R6 write full");
        access(0, 21'h12345, 16'h0,    2'b11, 16'hA5C3, 0, "R5 read full");
        access(1, 21'h12345, 16'h00FF, 2'b01, 16'h0, 0, "R3 write lower");
        access(0, 21'h12345, 16'h0,    2'b11, 16'hA5FF, 0, "R3 lower lane only");
        access(1, 21'h12345, 16'h7700, 2'b10, 16'h0, 0, "R3 write upper");
        access(0, 21'h12345, 16'h0,    2'b10, 16'h7700, 0, "R3 upper read, lower zero");
        access(0, 21'h12345, 16'h0,    2'b01, 16'h00FF, 0, "R3 lower read, upper zero");
        // R4: empty mask
        access(1, 21'h12345, 16'hFFFF, 2'b00, 16'h0, 0, "R4 empty mask");
        access(0, 21'h12345, 16'h0,    2'b11, 16'h77FF, 0, "R4 memory unchanged");
        // R10: read data holds across a write
        access(1, 21'h1FFFFF, 16'h1357, 2'b11, 16'h0, 0, "R6 top address write");
        chk(host_rdata === 16'h77FF, "R10 rdata held", host_rdata, 16'h77FF);
        access(0, 21'h1FFFFF, 16'h0, 2'b11, 16'h1357, 0, "R5 top address read");
        // R9: pulse during a busy write is ignored
        access(1, 21'h00005, 16'h1111, 2'b11, 16'h0, 1, "R9 busy write");
        access(0, 21'h00005, 16'h0, 2'b11, 16'h1111, 0, "R9 injected pulse ignored");
        // R7: read immediately followed by writes over several addresses
        for (int i = 0; i < 6; i++) begin
            access(1, 21'(i * 977), 16'(16'h3C00 + i * 257), 2'b11, 16'h0, 0, "R7 write after read");
            access(0, 21'(i * 977), 16'h0, 2'b11, 16'(16'h3C00 + i * 257), 0, "R5 readback");
        end
        repeat (5) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++; nfail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule